// File: doc/BRIEF.md
# Current-Balancing Three-Level PWM Steerer

This block lets a single three-level PWM channel from a multiphase controller drive two power phases. The input symbol is low, mid or high. The block produces two three-level outputs, A and B, and each output also has its own high-impedance flag. A one-bit flag from an external current comparator tells the block which phase now carries less current. The block reads that flag at the instant the input rises to high and sends the whole pulse to the lower-current phase. It does not force alternation, so a phase that is still lower at the next rise gets that pulse as well.

Several mode inputs change this behaviour. One turns the doubling on or off. One bypasses the steering so that both outputs copy the input. One decides how an output that is low reacts when the input falls from high to mid. The enable sequencer supplies an active signal, and a separate drive-on input parks both outputs at mid. Every output is registered, so each result appears one clock after the input it depends on.

Top module: `pwmSteerTop`

## Requirements
- R1: When seqActive is low, both hiz flags are 1 and both outputs read mid (2'b01) at the next clock. Reset gives the same state. This condition takes priority over every other input.
- R2: When seqActive is high and driveOn is low, both outputs are mid and both hiz flags are 0 at the next clock.
- R3: When the block is active, driveOn is high and bypass is high, both outputs equal the input symbol one clock later, for low, mid and high alike. Symbols are encoded low 2'b00, mid 2'b01, high 2'b10.
- R4: When the block is active, driveOn is high, bypass is low and dblEn is low, output A equals the input symbol one clock later and output B is held at mid.
- R5: In doubling mode (active, driveOn high, bypass low, dblEn high), the clock on which the input goes from not-high to high samples bLess. A value of 1 sends the pulse to B. A value of 0, which also covers equal currents, sends it to A. The chosen output goes high and the other output keeps its previous level.
- R6: In doubling mode, changes of bLess while the input stays high have no effect. A mid input that follows mid also leaves both outputs unchanged. Two pulses in a row go to the same output when bLess selects it at both rises.
- R7: In doubling mode with midHold high, a high-to-mid input step moves only the output that was high to mid. An output that was low stays low.
- R8: In doubling mode with midHold low, a high-to-mid input step sets both outputs to mid.
- R9: In doubling mode, a low-to-mid input step always sets both outputs to mid.
- R10: In doubling mode, a low input drives both outputs low.
- R11: The input code 2'b11 behaves exactly like mid in every mode, including how edges are detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| seqActive | input | 1 | Enable sequencer says the block is active |
| driveOn | input | 1 | Drive-on; when low, the outputs are parked at mid |
| dblEn | input | 1 | Doubling enable |
| bypass | input | 1 | Both outputs copy the input |
| midHold | input | 1 | On a high-to-mid step, a low output stays low |
| pwmIn | input | 2 | Three-level input symbol |
| bLess | input | 1 | Comparator flag: phase B current is lower |
| pwmA | output | 2 | Output A symbol |
| pwmB | output | 2 | Output B symbol |
| hizA | output | 1 | Output A is high impedance |
| hizB | output | 1 | Output B is high impedance |

## Verification
The bench toggles bLess in the middle of a pulse. A design that reads the flag on every cycle instead of only at the rise would then move the pulse from one output to the other. It applies high-to-mid steps with midHold set both ways. A design that mixes up the two rules would either lift the idle low output to mid or leave it low when it should move. It sends back-to-back pulses with an unchanged flag to catch designs that alternate by themselves. It also feeds code 2'b11 next to real high and low symbols, because a design that does not map that code to mid detects false edges. Long random pulse trains with random flag sequences and occasional mode changes are checked cycle by cycle against a reference model, so that errors in priority between modes show up.

// File: rtl/pwmSteerPkg.sv
package pwmSteerPkg;

  localparam int SYM_W = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_LOW  = 2'b00,
    SYM_MID  = 2'b01,
    SYM_HIGH = 2'b10,
    SYM_ALT  = 2'b11
  } sym_e;

  // Strobes from control to datapath; at most one action bit is set.
  typedef struct packed {
    logic forceOpen;
    logic forceMid;
    logic follow;
    logic single;
    logic allLow;
    logic riseHigh;
    logic selB;
    logic hiToMid;
    logic keepLow;
    logic loToMid;
  } strobe_t;

  function automatic sym_e normSym(input logic [SYM_W-1:0] raw);
    sym_e s;
    s = sym_e'(raw);
    if (s == SYM_ALT) s = SYM_MID;
    return s;
  endfunction

endpackage

// File: rtl/pwmSteerCtrl.sv
module pwmSteerCtrl
  import pwmSteerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqActive,
  input  logic             driveOn,
  input  logic             dblEn,
  input  logic             bypass,
  input  logic             midHold,
  input  logic [SYM_W-1:0] pwmIn,
  input  logic             bLess,
  output strobe_t          strobe,
  output sym_e             curSym
);

  sym_e prevSym;
  logic doubling;

  assign curSym   = normSym(pwmIn);
  assign doubling = seqActive && driveOn && !bypass && dblEn;

  // Previous input symbol, used to classify transitions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prevSym <= SYM_MID;
    else if (!seqActive) prevSym <= SYM_MID;
    else                 prevSym <= curSym;
  end

  always_comb begin
    strobe           = '0;
    strobe.forceOpen = !seqActive;
    strobe.forceMid  = seqActive && !driveOn;
    strobe.follow    = seqActive && driveOn && bypass;
    strobe.single    = seqActive && driveOn && !bypass && !dblEn;
    if (doubling) begin
      strobe.allLow   = (curSym == SYM_LOW);
      strobe.riseHigh = (curSym == SYM_HIGH) && (prevSym != SYM_HIGH);
      strobe.selB     = (curSym == SYM_HIGH) && (prevSym != SYM_HIGH) && bLess;
      strobe.hiToMid  = (curSym == SYM_MID) && (prevSym == SYM_HIGH);
      strobe.keepLow  = midHold;
      strobe.loToMid  = (curSym == SYM_MID) && (prevSym == SYM_LOW);
    end
  end

endmodule

// File: rtl/pwmSteerData.sv
module pwmSteerData
  import pwmSteerPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  sym_e    curSym,
  output sym_e    outA,
  output sym_e    outB,
  output logic    hizA,
  output logic    hizB
);

  sym_e nextA, nextB;
  logic nextHz;

  always_comb begin
    nextA  = outA;
    nextB  = outB;
    nextHz = 1'b0;
    if (strobe.forceOpen) begin
      nextA  = SYM_MID;
      nextB  = SYM_MID;
      nextHz = 1'b1;
    end else if (strobe.forceMid) begin
      nextA = SYM_MID;
      nextB = SYM_MID;
    end else if (strobe.follow) begin
      nextA = curSym;
      nextB = curSym;
    end else if (strobe.single) begin
      nextA = curSym;
      nextB = SYM_MID;
    end else if (strobe.allLow) begin
      nextA = SYM_LOW;
      nextB = SYM_LOW;
    end else if (strobe.riseHigh) begin
      if (strobe.selB) nextB = SYM_HIGH;
      else             nextA = SYM_HIGH;
    end else if (strobe.hiToMid) begin
      if (strobe.keepLow) begin
        if (outA == SYM_HIGH) nextA = SYM_MID;
        if (outB == SYM_HIGH) nextB = SYM_MID;
      end else begin
        nextA = SYM_MID;
        nextB = SYM_MID;
      end
    end else if (strobe.loToMid) begin
      nextA = SYM_MID;
      nextB = SYM_MID;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= SYM_MID;
      outB <= SYM_MID;
      hizA <= 1'b1;
      hizB <= 1'b1;
    end else begin
      outA <= nextA;
      outB <= nextB;
      hizA <= nextHz;
      hizB <= nextHz;
    end
  end

endmodule

// File: rtl/pwmSteerTop.sv
module pwmSteerTop
  import pwmSteerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqActive,
  input  logic             driveOn,
  input  logic             dblEn,
  input  logic             bypass,
  input  logic             midHold,
  input  logic [SYM_W-1:0] pwmIn,
  input  logic             bLess,
  output logic [SYM_W-1:0] pwmA,
  output logic [SYM_W-1:0] pwmB,
  output logic             hizA,
  output logic             hizB
);

  strobe_t strobe;
  sym_e    curSym;
  sym_e    outA, outB;

  pwmSteerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .seqActive(seqActive), .driveOn(driveOn),
    .dblEn(dblEn), .bypass(bypass), .midHold(midHold), .pwmIn(pwmIn),
    .bLess(bLess), .strobe(strobe), .curSym(curSym)
  );

  pwmSteerData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curSym(curSym),
    .outA(outA), .outB(outB), .hizA(hizA), .hizB(hizB)
  );

  assign pwmA = outA;
  assign pwmB = outB;

endmodule

// File: rtl/pwmSteerChk.sv
module pwmSteerChk (
  input logic       clk,
  input logic       rstN,
  input logic       seqActive,
  input logic       driveOn,
  input logic       dblEn,
  input logic       bypass,
  input logic       midHold,
  input logic [1:0] pwmIn,
  input logic       bLess,
  input logic [1:0] pwmA,
  input logic [1:0] pwmB,
  input logic       hizA,
  input logic       hizB
);

  p_open_r1: assert property (@(posedge clk) disable iff (!rstN)
    !seqActive |=> (hizA && hizB && pwmA == 2'b01 && pwmB == 2'b01));

  p_drive_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && !driveOn) |=> (!hizA && !hizB && pwmA == 2'b01 && pwmB == 2'b01));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && driveOn && bypass && pwmIn != 2'b11) |=>
      (pwmA == $past(pwmIn) && pwmB == $past(pwmIn)));

  p_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && driveOn && !bypass && !dblEn) |=> (pwmB == 2'b01));

  p_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && driveOn && !bypass && dblEn && pwmIn == 2'b00) |=>
      (pwmA == 2'b00 && pwmB == 2'b00));

  p_alt_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && driveOn && bypass && pwmIn == 2'b11) |=>
      (pwmA == 2'b01 && pwmB == 2'b01));

endmodule

bind pwmSteerTop pwmSteerChk uChk (
  .clk(clk), .rstN(rstN), .seqActive(seqActive), .driveOn(driveOn),
  .dblEn(dblEn), .bypass(bypass), .midHold(midHold), .pwmIn(pwmIn),
  .bLess(bLess), .pwmA(pwmA), .pwmB(pwmB), .hizA(hizA), .hizB(hizB)
);

// File: tb/tb_pwmSteerTop.sv
module tb_pwmSteerTop;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seqActive = 1'b0, driveOn = 1'b0, dblEn = 1'b0, bypass = 1'b0, midHold = 1'b0;
  logic [1:0] pwmIn = 2'b01;
  logic bLess = 1'b0;
  logic [1:0] pwmA, pwmB;
  logic hizA, hizB;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       hz;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  // Reference state built from the requirements
  logic [1:0] mA = 2'b01, mB = 2'b01, mPrev = 2'b01;
  logic       mHz = 1'b1;

  always #2 clk = ~clk;

  pwmSteerTop dut (
    .clk(clk), .rstN(rstN), .seqActive(seqActive), .driveOn(driveOn),
    .dblEn(dblEn), .bypass(bypass), .midHold(midHold), .pwmIn(pwmIn),
    .bLess(bLess), .pwmA(pwmA), .pwmB(pwmB), .hizA(hizA), .hizB(hizB)
  );

  task automatic step(input logic sa, input logic dOn, input logic de, input logic bp,
                      input logic mh, input logic [1:0] sym, input logic fl);
    logic [1:0] cur;
    exp_t e;
    string tag;
    @(negedge clk);
    seqActive = sa; driveOn = dOn; dblEn = de; bypass = bp; midHold = mh;
    pwmIn = sym; bLess = fl;
    cur = (sym == 2'b11) ? 2'b01 : sym;
    if (!sa) begin
      mA = 2'b01; mB = 2'b01; mHz = 1'b1; tag = "R1"; cur = 2'b01;
    end else begin
      mHz = 1'b0;
      if (!dOn) begin mA = 2'b01; mB = 2'b01; tag = "R2"; end
      else if (bp) begin mA = cur; mB = cur; tag = "R3"; end
      else if (!de) begin mA = cur; mB = 2'b01; tag = "R4"; end
      else if (cur == 2'b00) begin mA = 2'b00; mB = 2'b00; tag = "R10"; end
      else if (cur == 2'b10 && mPrev != 2'b10) begin
        if (fl) mB = 2'b10; else mA = 2'b10;
        tag = "R5";
      end else if (cur == 2'b01 && mPrev == 2'b10) begin
        if (mh) begin
          if (mA == 2'b10) mA = 2'b01;
          if (mB == 2'b10) mB = 2'b01;
          tag = "R7";
        end else begin
          mA = 2'b01; mB = 2'b01; tag = "R8";
        end
      end else if (cur == 2'b01 && mPrev == 2'b00) begin
        mA = 2'b01; mB = 2'b01; tag = "R9";
      end else tag = "R6";
      if (sym == 2'b11) tag = "R11";
    end
    mPrev = cur;
    e.a = mA; e.b = mB; e.hz = mHz; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic dbl(input logic mh, input logic [1:0] sym, input logic fl);
    step(1'b1, 1'b1, 1'b1, 1'b0, mh, sym, fl);
  endtask

  // Monitor: results of inputs driven at a falling edge appear after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (pwmA !== e.a || pwmB !== e.b || hizA !== e.hz || hizB !== e.hz) begin
          errors++;
          $display("FAIL %s: got A=%b B=%b hz=%b%b expected A=%b B=%b hz=%b",
                   e.tag, pwmA, pwmB, hizA, hizB, e.a, e.b, e.hz);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (hizA !== 1'b1 || hizB !== 1'b1 || pwmA !== 2'b01 || pwmB !== 2'b01) begin
      errors++;
      $display("FAIL R1 reset: got A=%b B=%b hz=%b%b expected A=01 B=01 hz=11",
               pwmA, pwmB, hizA, hizB);
    end
    rstN = 1'b1;

    // R1 inactive, R2 drive off
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
    // R3 bypass over all levels, R11 alternate code
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
    // R4 doubling off
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1);
    // R10, R5 to A, R6 flag flips mid-pulse, R8
    dbl(1'b0, 2'b00, 1'b0);
    dbl(1'b0, 2'b10, 1'b0);
    dbl(1'b0, 2'b10, 1'b1);
    dbl(1'b0, 2'b10, 1'b1);
    dbl(1'b0, 2'b01, 1'b1);
    // R7: low output stays low
    dbl(1'b1, 2'b00, 1'b1);
    dbl(1'b1, 2'b10, 1'b1);
    dbl(1'b1, 2'b10, 1'b0);
    dbl(1'b1, 2'b01, 1'b0);
    dbl(1'b1, 2'b01, 1'b1);
    // R9 low to mid
    dbl(1'b1, 2'b00, 1'b0);
    dbl(1'b1, 2'b01, 1'b0);
    // R6 consecutive pulses to A
    dbl(1'b1, 2'b00, 1'b0);
    dbl(1'b1, 2'b10, 1'b0);
    dbl(1'b1, 2'b00, 1'b0);
    dbl(1'b1, 2'b10, 1'b0);
    dbl(1'b1, 2'b00, 1'b0);
    // R11: 11 between high and high is a mid, so a new rise follows
    dbl(1'b0, 2'b10, 1'b1);
    dbl(1'b0, 2'b11, 1'b1);
    dbl(1'b0, 2'b10, 1'b0);
    dbl(1'b0, 2'b00, 1'b0);

    // Random pulse trains with random flags and occasional mode changes
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] sym;
      logic sa, dOn, de, bp;
      int r;
      r = $urandom_range(0, 99);
      sa = (r != 0); dOn = (r != 1); de = (r > 4); bp = (r == 2 || r == 3);
      sym = 2'($urandom_range(0, 3));
      step(sa, dOn, de, bp, 1'($urandom_range(0, 1)), sym, 1'($urandom_range(0, 1)));
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule